// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block sits between a serial receiver and the register that software reads. Each character that the receiver delivers is written into a 16-entry first-in first-out store along with two tag bits: one marking a framing error and one marking a parity error for that character. The tags are kept with the data, so software can tell which character was bad. A global sticky error flag would only say that some character failed.

Software reads one 16-bit word per access. The word holds the character and its tags, and each access removes one entry. The tags therefore cannot be separated from their data. The block also reports how full it is, raises a sticky overflow flag when the receiver writes into a full store, and can be emptied with a dedicated flush input. Only the block reset and the flush input discard stored entries. No other receiver control affects them.

Top module: `rx_tag_fifo`

## Requirements
- R1: The read word `rd_word` holds the framing-error tag in bit 15, the parity-error tag in bit 14, zeros in bits 13 to 8, and the character in bits 7 to 0.
- R2: Entries are read out in the order they were written.
- R3: Each tag reads back as set only on the entry that was written with it set. Neighbouring entries read with their tags clear.
- R4: A cycle with `rd_en` high on a non-empty FIFO removes exactly one entry. At the same clock edge, `rd_word` is loaded with that entry, so it is valid from the following cycle.
- R5: A write (`wr_en`) to a full FIFO with no read in the same cycle is discarded. The stored contents are left unchanged and `ovf` is set.
- R6: `ovf` stays set until `ovf_clr` is high at a clock edge. If an overflow happens in the same cycle as `ovf_clr`, the flag stays set.
- R7: `flush` empties the FIFO and sets `level` to 0. It leaves `ovf` and `rd_word` unchanged. A read or write in the same cycle as `flush` has no effect.
- R8: A read from an empty FIFO leaves `rd_word` at its last value and `level` at 0.
- R9: `level` counts stored entries from 0 to 16. A read and a write in the same cycle leave `level` unchanged. When the FIFO is full, such a write is accepted and no overflow is raised.
- R10: After reset, `level` is 0, `ovf` is 0 and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers one character this cycle |
| wr_data | input | 8 | Received character |
| wr_fe | input | 1 | Framing-error tag for this character |
| wr_pe | input | 1 | Parity-error tag for this character |
| rd_en | input | 1 | Read access; pops one entry |
| rd_word | output | 16 | Tags and character of the last entry read |
| level | output | 5 | Number of stored entries, 0 to 16 |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| flush | input | 1 | Empties the FIFO |

## Verification
The hardest situation to reach is the full store, where a read and a write land in the same cycle, or where an overflow coincides with the flag clear. Both need sixteen writes first, followed by one precisely placed combined cycle. The bench fills the store with numbered characters. It then drives those combined cycles and drains everything. This confirms that the discarded write left no trace, and that the accepted write shows up last in the order.

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        wr_fe,
  input  logic        wr_pe,
  input  logic        rd_en,
  output logic [15:0] rd_word,
  output logic [4:0]  level,
  output logic        ovf,
  input  logic        ovf_clr,
  input  logic        flush
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [4:0] FULL_LVL = 5'(DEPTH);
  localparam int PAD = 14 - DW;

  logic [DW-1:0] mem_d  [DEPTH];
  logic          mem_fe [DEPTH];
  logic          mem_pe [DEPTH];
  logic [AW-1:0] wptr, rptr;

  wire empty = (level == 5'd0);
  wire full  = (level == FULL_LVL);
  wire pop   = rd_en && !empty && !flush;
  wire push  = wr_en && (!full || pop) && !flush;
  wire lost  = wr_en && full && !pop && !flush;

  always_ff @(posedge clk)
    if (push) begin
      mem_d[wptr]  <= wr_data[DW-1:0];
      mem_fe[wptr] <= wr_fe;
      mem_pe[wptr] <= wr_pe;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (push && !pop)      level <= level + 5'd1;
      else if (pop && !push) level <= level - 5'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_word <= '0;
    else if (pop) rd_word <= {mem_fe[rptr], mem_pe[rptr], {PAD{1'b0}}, mem_d[rptr]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf <= 1'b0;
    else if (lost) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);                                                   // R9
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (level == FULL_LVL && ovf));  // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);                                           // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == 5'd0 && $stable(rd_word)));                       // R7
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> ($stable(rd_word) && level == 5'd0));            // R8
  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && !empty && !flush) |=> $stable(level));             // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[13:8] == 6'd0);                                               // R1
endmodule

// File: tb/rx_tag_fifo_tb.sv
module rx_tag_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // row: wr, fe, pe, data[8], rd, expected word[16], expected level[5]
  localparam logic [32:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'hA5,1'b0,16'h0000,5'd1},
    {1'b1,1'b0,1'b1,8'h3C,1'b0,16'h0000,5'd2},
    {1'b1,1'b1,1'b0,8'h81,1'b0,16'h0000,5'd3},
    {1'b0,1'b0,1'b0,8'h00,1'b1,16'h00A5,5'd2},
    {1'b1,1'b1,1'b1,8'h7E,1'b1,16'h403C,5'd2},
    {1'b0,1'b0,1'b0,8'h00,1'b1,16'h8081,5'd1},
    {1'b0,1'b0,1'b0,8'h00,1'b1,16'hC07E,5'd0},
    {1'b0,1'b0,1'b0,8'h00,1'b1,16'hC07E,5'd0},
    {1'b1,1'b0,1'b0,8'h00,1'b0,16'hC07E,5'd1},
    {1'b0,1'b0,1'b0,8'h00,1'b1,16'h0000,5'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_fe = 0, wr_pe = 0, rd_en = 0, ovf_clr = 0, flush = 0;
  logic [7:0] wr_data = '0;
  logic [15:0] rd_word;
  logic [4:0] level;
  logic ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tag_fifo dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_fe(wr_fe), .wr_pe(wr_pe), .rd_en(rd_en), .rd_word(rd_word), .level(level),
    .ovf(ovf), .ovf_clr(ovf_clr), .flush(flush));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic fe, input logic pe, input logic [7:0] d,
                      input logic r, input logic clr, input logic fl);
    wr_en = w; wr_fe = fe; wr_pe = pe; wr_data = d; rd_en = r; ovf_clr = clr; flush = fl;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_fe = 0; wr_pe = 0; wr_data = '0; rd_en = 0; ovf_clr = 0; flush = 0;
  endtask

  task automatic fill16();
    for (int i = 0; i < 16; i++) step(1, i[0], i[1], 8'(i + 16), 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 level", 16'(level), 16'd0);
    chk("R10 ovf", 16'(ovf), 16'd0);
    chk("R10 word", rd_word, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][32], VEC[v][31], VEC[v][30], VEC[v][29:22], VEC[v][21], 0, 0);
      chk("R1 R2 R3 R4 R8 word", rd_word, VEC[v][20:5]);
      chk("R4 R9 level", 16'(level), 16'(VEC[v][4:0]));
    end

    fill16();
    chk("R9 level full", 16'(level), 16'd16);
    chk("R9 no ovf yet", 16'(ovf), 16'd0);
    step(1, 1, 1, 8'hEE, 0, 0, 0);
    chk("R5 level kept", 16'(level), 16'd16);
    chk("R5 ovf set", 16'(ovf), 16'd1);
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 8'h00, 1, 0, 0);
      chk("R5 R2 contents kept", rd_word, {i[0], i[1], 6'd0, 8'(i + 16)});
    end
    chk("R6 ovf sticky", 16'(ovf), 16'd1);

    fill16();
    step(1, 0, 0, 8'hEE, 0, 1, 0);
    chk("R6 set wins over clear", 16'(ovf), 16'd1);
    step(0, 0, 0, 8'h00, 0, 1, 0);
    chk("R6 clear", 16'(ovf), 16'd0);
    step(1, 0, 1, 8'h99, 1, 0, 0);
    chk("R9 full read+write level", 16'(level), 16'd16);
    chk("R9 full read+write no ovf", 16'(ovf), 16'd0);
    chk("R9 read word", rd_word, 16'h0010);
    for (int i = 1; i < 16; i++) step(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R2 before last", rd_word, {1'b1, 1'b1, 6'd0, 8'h1F});
    step(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R9 accepted write last", rd_word, 16'h4099);

    step(1, 0, 0, 8'h11, 0, 0, 0);
    step(1, 0, 0, 8'h22, 0, 0, 0);
    step(0, 0, 0, 8'h00, 0, 0, 0);
    fill16();
    step(1, 0, 0, 8'h55, 0, 0, 0);
    chk("R5 ovf again", 16'(ovf), 16'd1);
    step(1, 0, 0, 8'h66, 1, 0, 1);
    chk("R7 flush level", 16'(level), 16'd0);
    chk("R7 flush keeps ovf", 16'(ovf), 16'd1);
    chk("R7 flush keeps word", rd_word, 16'h4099);
    step(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R8 empty read word", rd_word, 16'h4099);
    chk("R8 empty read level", 16'(level), 16'd0);
    step(1, 1, 0, 8'h5A, 0, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R7 flushed data gone", rd_word, 16'h805A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule